// File: doc/BRIEF.md
# Grouped Double-Buffered Compare Latch Bank

Seven compare channels, numbered 0 to 6, each pair a software-written compare register with a shadow latch. The latch is the value a comparator outside this block uses. Each channel has a 2-bit load-event selector that decides when the register is copied into the latch. The latch can load at once on a write, or wait for a counter event: the counter reaching zero, reaching its period bound, or matching that channel's own latch. Deferring the copy lets software stage new compare values at any time without glitching an active period.

A global group code can gang channels so that one leader channel's load-event selector and event decide when every member latch loads. All members load on the same clock edge, and each takes its own pending register value. The counter, the comparators, the outputs and any interrupts live outside this block. Counter events arrive as single-cycle pulses.

Top module: `cmp_latch_bank`

## Requirements
- R1: While reset is asserted, and after it, every compare register and every latch holds zero, so all of `lat_o` reads zero.
- R2: With selector 0 (load on write) on an independent channel, a write updates that channel's latch on the same clock edge as its register.
- R3: With a nonzero selector, a write changes only the register. The latch keeps its old value until the selected event fires.
- R4: Selector 1 loads the latch on the edge where `zero_i` pulses.
- R5: Selector 2 loads on `zero_i` in counter modes up (1) and continuous (2), ignoring `period_i`. In up/down mode (3) it loads on either `zero_i` or `period_i`.
- R6: Selector 3 loads only on that channel's own `match_i` bit. Matches on other channels and `zero_i` have no effect.
- R7: Group code 0 makes every channel follow only its own selector and events.
- R8: Group code 1 forms pairs {1,2}, {3,4} and {5,6}, each led by its lower channel. Channel 0 stays independent.
- R9: Group code 2 forms triplets {1,2,3}, led by channel 1, and {4,5,6}, led by channel 4. Channel 0 stays independent.
- R10: Group code 3 ties all seven channels to channel 1's selector and events.
- R11: When a write and the load event fall on the same edge, the latch takes the newly written data.
- R12: In a group whose leader uses selector 0, a write to a member only updates that member's register. A write to the leader loads every latch of the group from its own register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| grp_i | input | 2 | Group code: 0 none, 1 pairs, 2 triplets, 3 all |
| cnt_mode_i | input | 2 | Counter mode: 0 stop, 1 up, 2 continuous, 3 up/down |
| ld_evt_i | input | 14 | Load-event selector of channel n at bits [2n+1:2n] |
| wr_en_i | input | 7 | Per-channel compare register write strobe, bit n = channel n |
| wr_data_i | input | 16 | Compare write data |
| zero_i | input | 1 | Counter reached zero (one-cycle pulse) |
| period_i | input | 1 | Counter reached period bound (one-cycle pulse) |
| match_i | input | 7 | Counter equals channel n latch (one-cycle pulse), bit n |
| lat_o | output | 112 | Latch values, channel n at bits [16n+15:16n] |

## Verification
Every latch update is due on the rising edge that samples the write strobe or event pulse, so it shows on `lat_o` one edge after the stimulus is driven. Stimulus changes on falling edges, and each vector is checked at the falling edge after the capturing rising edge. Each check therefore sees exactly one cycle of effect. The tests that expect no load use the same point to show the old value is still held. The reset check during the run samples `lat_o` while reset is low, with no clock edge needed.

// File: rtl/cmp_latch_pkg.sv
package cmp_latch_pkg;

  localparam int NUM_CH = 7;

  typedef enum logic [1:0] {
    LD_ON_WRITE = 2'd0,
    LD_AT_ZERO  = 2'd1,
    LD_AT_BOUND = 2'd2,
    LD_AT_MATCH = 2'd3
  } ld_evt_e;

  typedef enum logic [1:0] {
    CNT_STOP = 2'd0,
    CNT_UP   = 2'd1,
    CNT_CONT = 2'd2,
    CNT_UPDN = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_PAIR = 2'd1,
    GRP_TRIO = 2'd2,
    GRP_ALL  = 2'd3
  } grp_e;

  // leader channel whose trigger drives channel ch under group code g
  function automatic logic [2:0] leader_of(input int ch, input grp_e g);
    int l;
    unique case (g)
      GRP_NONE: l = ch;
      GRP_PAIR: l = (ch == 0) ? 0 : ((ch - 1) / 2) * 2 + 1;
      GRP_TRIO: l = (ch == 0) ? 0 : ((ch - 1) / 3) * 3 + 1;
      default:  l = 1;
    endcase
    return 3'(l);
  endfunction

endpackage

// File: rtl/cmp_trig.sv
module cmp_trig
  import cmp_latch_pkg::*;
(
  input  ld_evt_e   sel_i,
  input  cnt_mode_e mode_i,
  input  logic      wr_i,
  input  logic      zero_i,
  input  logic      period_i,
  input  logic      match_i,
  output logic      trig_o
);

  always_comb begin
    unique case (sel_i)
      LD_ON_WRITE: trig_o = wr_i;
      LD_AT_ZERO:  trig_o = zero_i;
      LD_AT_BOUND: trig_o = (mode_i == CNT_UPDN) ? (zero_i | period_i) : zero_i;
      default:     trig_o = match_i;
    endcase
  end

endmodule

// File: rtl/cmp_group_route.sv
module cmp_group_route
  import cmp_latch_pkg::*;
(
  input  grp_e              grp_i,
  input  logic [NUM_CH-1:0] trig_i,
  output logic [NUM_CH-1:0] fire_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [2:0] lead;
    always_comb begin
      lead      = leader_of(c, grp_i);
      fire_o[c] = trig_i[lead];
    end
  end

endmodule

// File: rtl/cmp_latch_ch.sv
module cmp_latch_ch #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fire_i,
  output logic [DATA_W-1:0] lat_o
);

  logic [DATA_W-1:0] reg_q, lat_q, reg_nxt;

  // same-edge write wins over the stored value
  assign reg_nxt = wr_i ? wr_data_i : reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      lat_q <= '0;
    end else begin
      reg_q <= reg_nxt;
      if (fire_i) lat_q <= reg_nxt;
    end
  end

  assign lat_o = lat_q;

  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(lat_q));

  // R11
  same_edge_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && wr_i) |=> lat_q == $past(wr_data_i));

  // R12
  reg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> reg_q == $past(wr_data_i));

endmodule

// File: rtl/cmp_latch_bank.sv
module cmp_latch_bank
  import cmp_latch_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [1:0]                 grp_i,
  input  logic [1:0]                 cnt_mode_i,
  input  logic [2*NUM_CH-1:0]        ld_evt_i,
  input  logic [NUM_CH-1:0]          wr_en_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  input  logic                       zero_i,
  input  logic                       period_i,
  input  logic [NUM_CH-1:0]          match_i,
  output logic [NUM_CH*DATA_W-1:0]   lat_o
);

  logic [NUM_CH-1:0] trig, fire;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmp_trig u_trig (
      .sel_i    (ld_evt_e'(ld_evt_i[2*c +: 2])),
      .mode_i   (cnt_mode_e'(cnt_mode_i)),
      .wr_i     (wr_en_i[c]),
      .zero_i   (zero_i),
      .period_i (period_i),
      .match_i  (match_i[c]),
      .trig_o   (trig[c])
    );

    cmp_latch_ch #(.DATA_W(DATA_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_en_i[c]),
      .wr_data_i (wr_data_i),
      .fire_i    (fire[c]),
      .lat_o     (lat_o[c*DATA_W +: DATA_W])
    );
  end

  cmp_group_route u_route (
    .grp_i  (grp_e'(grp_i)),
    .trig_i (trig),
    .fire_o (fire)
  );

  // R7
  grp_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_i == 2'd0 |-> fire == trig);

  // R8
  grp_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_i == 2'd1 |-> (fire[1] == fire[2] && fire[3] == fire[4] &&
                       fire[5] == fire[6] && fire[0] == trig[0]));

  // R9
  grp_trio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_i == 2'd2 |-> (fire[1] == fire[2] && fire[2] == fire[3] &&
                       fire[4] == fire[5] && fire[5] == fire[6] &&
                       fire[0] == trig[0]));

  // R10
  grp_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_i == 2'd3 |-> ($countones(fire) == 0 || $countones(fire) == NUM_CH));

endmodule

// File: tb/cmp_latch_bank_tb.sv
`timescale 1ns/1ps
module cmp_latch_bank_tb;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   grp_i = '0;
  logic [1:0]   cnt_mode_i = '0;
  logic [13:0]  ld_evt_i = '0;
  logic [6:0]   wr_en_i = '0;
  logic [15:0]  wr_data_i = '0;
  logic         zero_i = 1'b0;
  logic         period_i = 1'b0;
  logic [6:0]   match_i = '0;
  logic [111:0] lat_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cmp_latch_bank u_dut (
    .clk_i, .rst_ni, .grp_i, .cnt_mode_i, .ld_evt_i, .wr_en_i,
    .wr_data_i, .zero_i, .period_i, .match_i, .lat_o
  );

  typedef struct packed {
    logic [1:0]  grp;
    logic [13:0] ld;
    logic [1:0]  md;
    logic [6:0]  we;
    logic [15:0] d;
    logic        z;
    logic        p;
    logic [6:0]  m;
    logic [2:0]  ch;
    logic [15:0] ex;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 14'h0000, 2'd0, 7'h04, 16'h1111, 1'b0, 1'b0, 7'h00, 3'd2, 16'h1111}, // R2
    '{2'd0, 14'h1555, 2'd0, 7'h08, 16'h2222, 1'b0, 1'b0, 7'h00, 3'd3, 16'h0000}, // R3
    '{2'd0, 14'h1555, 2'd0, 7'h00, 16'h0000, 1'b1, 1'b0, 7'h00, 3'd3, 16'h2222}, // R4
    '{2'd0, 14'h2AAA, 2'd1, 7'h10, 16'h3333, 1'b0, 1'b1, 7'h00, 3'd4, 16'h0000}, // R5
    '{2'd0, 14'h2AAA, 2'd3, 7'h00, 16'h0000, 1'b0, 1'b1, 7'h00, 3'd4, 16'h3333}, // R5
    '{2'd0, 14'h3FFF, 2'd0, 7'h20, 16'h4444, 1'b1, 1'b0, 7'h00, 3'd5, 16'h0000}, // R6
    '{2'd0, 14'h3FFF, 2'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 7'h40, 3'd5, 16'h0000}, // R7
    '{2'd0, 14'h3FFF, 2'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 7'h20, 3'd5, 16'h4444}, // R6
    '{2'd0, 14'h1555, 2'd0, 7'h40, 16'h5555, 1'b1, 1'b0, 7'h00, 3'd6, 16'h5555}, // R11
    '{2'd1, 14'h0004, 2'd0, 7'h04, 16'h6666, 1'b0, 1'b0, 7'h00, 3'd2, 16'h1111}, // R8
    '{2'd1, 14'h0004, 2'd0, 7'h00, 16'h0000, 1'b1, 1'b0, 7'h00, 3'd2, 16'h6666}, // R8
    '{2'd1, 14'h0004, 2'd0, 7'h01, 16'h7777, 1'b0, 1'b0, 7'h00, 3'd0, 16'h7777}, // R8
    '{2'd2, 14'h0300, 2'd0, 7'h40, 16'h8888, 1'b0, 1'b0, 7'h00, 3'd6, 16'h5555}, // R9
    '{2'd2, 14'h0300, 2'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 7'h40, 3'd6, 16'h5555}, // R9
    '{2'd2, 14'h0300, 2'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 7'h10, 3'd6, 16'h8888}, // R9
    '{2'd3, 14'h0004, 2'd0, 7'h01, 16'h9999, 1'b0, 1'b0, 7'h00, 3'd0, 16'h7777}, // R10
    '{2'd3, 14'h0004, 2'd0, 7'h00, 16'h0000, 1'b1, 1'b0, 7'h00, 3'd0, 16'h9999}, // R10
    '{2'd3, 14'h0000, 2'd0, 7'h20, 16'hAAAA, 1'b0, 1'b0, 7'h00, 3'd5, 16'h4444}, // R12
    '{2'd3, 14'h0000, 2'd0, 7'h02, 16'hBBBB, 1'b0, 1'b0, 7'h00, 3'd5, 16'hAAAA}, // R12
    '{2'd0, 14'h0000, 2'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 7'h00, 3'd1, 16'hBBBB}  // R7
  };

  function automatic string req_of(int i);
    case (i)
      0: return "R2";   1: return "R3";   2: return "R4";
      3, 4: return "R5";
      5, 7: return "R6";
      6, 19: return "R7";
      8: return "R11";
      9, 10, 11: return "R8";
      12, 13, 14: return "R9";
      15, 16: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, int ch, logic [15:0] exp);
    logic [15:0] got;
    got = lat_o[ch*16 +: 16];
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d: got %h expected %h", req, ch, got, exp);
    end
  endtask

  task automatic idle();
    grp_i = '0; cnt_mode_i = '0; ld_evt_i = '0; wr_en_i = '0;
    wr_data_i = '0; zero_i = 1'b0; period_i = 1'b0; match_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    for (int c = 0; c < 7; c++) check("R1", c, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++) begin
      grp_i = VEC[i].grp; ld_evt_i = VEC[i].ld; cnt_mode_i = VEC[i].md;
      wr_en_i = VEC[i].we; wr_data_i = VEC[i].d; zero_i = VEC[i].z;
      period_i = VEC[i].p; match_i = VEC[i].m;
      @(posedge clk_i);
      @(negedge clk_i);
      check(req_of(i), int'(VEC[i].ch), VEC[i].ex);
    end
    idle();
    // R1: asynchronous reset mid-run clears every latch
    rst_ni = 1'b0;
    #1;
    for (int c = 0; c < 7; c++) check("R1", c, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule